// File: doc/BRIEF.md
# Dual-Issue Dispatch Pairing Unit

This unit sits between decode and the execution pipes of an in-order core that can start two instructions per cycle. Every cycle it looks at the two oldest decoded instructions (slot 0 older, slot 1 younger). It decides whether none, only slot 0, or both start. It also routes each started instruction to one of three pipes: a load/store pipe, a complex-integer pipe, and a simple-integer pipe. The route depends on the instruction's operation class and on its condition-register and exception-register update flags.

Hazard state sits in two countdown scoreboards. One per general-purpose register tracks load results. One per condition-register field tracks results of long-latency condition producers. A miss tracker blocks the destination of a load that missed in the data cache until the fill is reported. The tracker is a two-state machine. `ST_RUN` is the idle state. It moves to `ST_WAIT_FILL` on a cycle with `dc_miss` high, and it latches `dc_miss_tag`. `ST_WAIT_FILL` blocks reads of the latched register and returns to `ST_RUN` on a cycle with `fill_done` high. A miss reported while already waiting is not accepted.

The dispatch decision is combinational from the slot inputs and the registered hazard state. Scoreboard updates take effect at the clock edge that ends the dispatch cycle.

Top module: `dual_issue_pairer`

## Requirements
- R1: Class codes are ALU=0, LOAD=1, STORE=2, BRANCH=3, MULDIV=4, SYS=5, SPR=6, MTCR=7. Pipe codes are NONE=0, L=1, I=2, J=3. A dispatched LOAD or STORE always gets pipe L.
- R2: A dispatched BRANCH, MULDIV, SYS, SPR or MTCR, or an ALU instruction with `cr_wr` or `xer_wr` set, always gets pipe I.
- R3: An ALU instruction with neither update flag is flexible. When both slots are flexible, slot 0 takes I and slot 1 takes J. When the other slot is dispatched and is I-only, the flexible one takes J. When slot 0 is flexible and dispatches alone, it takes I.
- R4: Slot 1 does not dispatch when both slots need pipe L, or when both are I-only.
- R5: Dispatch is in order. An invalid or stalled slot 0 means slot 1 does not dispatch. An undispatched slot shows pipe NONE.
- R6: Slot 1 does not dispatch with slot 0 when it reads (through `ra` or `rb`) the register that slot 0 writes. It also does not dispatch when it reads the condition-register field that slot 0 writes.
- R7: An instruction that reads the destination of a LOAD dispatched in cycle t is stalled in cycles t+1 and t+2, and may dispatch in cycle t+3.
- R8: A BRANCH reading a field written by an ALU condition update dispatched in cycle t may dispatch in cycle t+1.
- R9: A BRANCH reading a field written by any non-ALU condition update (multiply/divide, move-to-condition-fields, store-conditional, system search) dispatched in cycle t is stalled in t+1 and may dispatch in t+2.
- R10: `dc_miss` with `dc_miss_tag` in cycle c blocks readers of that register from cycle c+1. With `fill_done` in cycle f, readers may dispatch again from cycle f+1. Readers of other registers are unaffected.
- R11: After reset all scoreboard entries are free, the tracker is in `ST_RUN`, and invalid slots produce no dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_cls | input | 3 | Slot 0 operation class |
| s0_ra | input | 5 | Slot 0 first source register |
| s0_ra_en | input | 1 | Slot 0 reads `s0_ra` |
| s0_rb | input | 5 | Slot 0 second source register |
| s0_rb_en | input | 1 | Slot 0 reads `s0_rb` |
| s0_rd | input | 5 | Slot 0 destination register |
| s0_rd_en | input | 1 | Slot 0 writes `s0_rd` |
| s0_cr_wr | input | 1 | Slot 0 updates condition field `s0_crf` |
| s0_xer_wr | input | 1 | Slot 0 updates the exception register |
| s0_cr_rd | input | 1 | Slot 0 reads condition field `s0_crf` |
| s0_crf | input | 3 | Slot 0 condition field index |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_cls | input | 3 | Slot 1 operation class |
| s1_ra | input | 5 | Slot 1 first source register |
| s1_ra_en | input | 1 | Slot 1 reads `s1_ra` |
| s1_rb | input | 5 | Slot 1 second source register |
| s1_rb_en | input | 1 | Slot 1 reads `s1_rb` |
| s1_rd | input | 5 | Slot 1 destination register |
| s1_rd_en | input | 1 | Slot 1 writes `s1_rd` |
| s1_cr_wr | input | 1 | Slot 1 updates condition field `s1_crf` |
| s1_xer_wr | input | 1 | Slot 1 updates the exception register |
| s1_cr_rd | input | 1 | Slot 1 reads condition field `s1_crf` |
| s1_crf | input | 3 | Slot 1 condition field index |
| dc_miss | input | 1 | A dispatched load missed in the data cache |
| dc_miss_tag | input | 5 | Destination register of the missing load |
| fill_done | input | 1 | The outstanding miss has been filled |
| s0_go | output | 1 | Slot 0 dispatches this cycle |
| s0_pipe | output | 2 | Pipe chosen for slot 0 |
| s1_go | output | 1 | Slot 1 dispatches this cycle |
| s1_pipe | output | 2 | Pipe chosen for slot 1 |

## Verification
Pairing and pipe choice have no delay: they are due in the same cycle the slots are presented. The bench drives the slots on the falling edge and samples the outputs shortly afterwards, before the next rising edge. Scoreboard effects are counted from the dispatch cycle t: load consumers are checked as blocked at t+1 and t+2 and free at t+3, and long-latency branches as blocked at t+1 and free at t+2. The miss tracker is registered, so a miss or fill in cycle c is observed at c+1. The bench advances one rising edge per cycle and checks at each of those offsets. It idles the slots between scenarios until every counter has drained.

// File: rtl/dp_pkg.sv
package dp_pkg;

    typedef enum logic [2:0] {
        CL_ALU    = 3'd0,
        CL_LOAD   = 3'd1,
        CL_STORE  = 3'd2,
        CL_BRANCH = 3'd3,
        CL_MULDIV = 3'd4,
        CL_SYS    = 3'd5,
        CL_SPR    = 3'd6,
        CL_MTCR   = 3'd7
    } op_cls_e;

    typedef enum logic [1:0] {
        PIPE_NONE = 2'd0,
        PIPE_L    = 2'd1,
        PIPE_I    = 2'd2,
        PIPE_J    = 2'd3
    } pipe_e;

    typedef struct packed {
        logic to_l;
        logic i_only;
        logic flex;
        logic long_cr;
        logic is_load;
    } cls_info_t;

endpackage

// File: rtl/dp_classify.sv
module dp_classify
    import dp_pkg::*;
(
    input  logic [2:0] cls,
    input  logic       cr_wr,
    input  logic       xer_wr,
    output cls_info_t  info
);
    always_comb begin
        info = '0;
        unique case (op_cls_e'(cls))
            CL_LOAD: begin
                info.to_l    = 1'b1;
                info.is_load = 1'b1;
            end
            CL_STORE:  info.to_l = 1'b1;
            CL_ALU: begin
                info.i_only = cr_wr | xer_wr;
                info.flex   = ~(cr_wr | xer_wr);
            end
            CL_BRANCH, CL_MULDIV, CL_SYS, CL_SPR, CL_MTCR: info.i_only = 1'b1;
            default: info = '0;
        endcase
        info.long_cr = cr_wr & (op_cls_e'(cls) != CL_ALU);
    end
endmodule

// File: rtl/dp_countdown_sb.sv
module dp_countdown_sb #(
    parameter int ENTRIES = 32,
    parameter int MAXV    = 2,
    localparam int IW     = $clog2(ENTRIES),
    localparam int CW     = $clog2(MAXV + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_a_en,
    input  logic [IW-1:0]      set_a_idx,
    input  logic               set_b_en,
    input  logic [IW-1:0]      set_b_idx,
    output logic [ENTRIES-1:0] busy
);
    genvar i;
    generate
        for (i = 0; i < ENTRIES; i++) begin : g_ent
            logic [CW-1:0] cnt_q;
            logic          hit;

            assign hit = (set_a_en && set_a_idx == IW'(i)) ||
                         (set_b_en && set_b_idx == IW'(i));

            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (hit)
                    cnt_q <= CW'(MAXV);
                else if (cnt_q != '0)
                    cnt_q <= cnt_q - CW'(1);
            end

            assign busy[i] = (cnt_q != '0);

            assert_busy_after_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
                hit |=> busy[i]);
        end
    endgenerate
endmodule

// File: rtl/dp_miss_fsm.sv
module dp_miss_fsm #(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dc_miss,
    input  logic [IW-1:0] dc_miss_tag,
    input  logic          fill_done,
    output logic          blk_en,
    output logic [IW-1:0] blk_tag
);
    typedef enum logic {ST_RUN, ST_WAIT_FILL} miss_st_e;

    miss_st_e      state_q, state_d;
    logic [IW-1:0] tag_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (dc_miss)   state_d = ST_WAIT_FILL;
            ST_WAIT_FILL: if (fill_done) state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && dc_miss)
                tag_q <= dc_miss_tag;
        end
    end

    always_comb begin
        blk_en  = (state_q == ST_WAIT_FILL);
        blk_tag = tag_q;
    end

    assert_miss_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_en) |-> $past(dc_miss));
    assert_fill_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && fill_done) |=> !blk_en);
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
    import dp_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int NCRF    = 8,
    parameter int LD_GAP  = 3,
    parameter int CR_HOLD = 1,
    localparam int RW     = $clog2(NREG),
    localparam int FW     = $clog2(NCRF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s0_valid,
    input  logic [2:0]    s0_cls,
    input  logic [RW-1:0] s0_ra,
    input  logic          s0_ra_en,
    input  logic [RW-1:0] s0_rb,
    input  logic          s0_rb_en,
    input  logic [RW-1:0] s0_rd,
    input  logic          s0_rd_en,
    input  logic          s0_cr_wr,
    input  logic          s0_xer_wr,
    input  logic          s0_cr_rd,
    input  logic [FW-1:0] s0_crf,
    input  logic          s1_valid,
    input  logic [2:0]    s1_cls,
    input  logic [RW-1:0] s1_ra,
    input  logic          s1_ra_en,
    input  logic [RW-1:0] s1_rb,
    input  logic          s1_rb_en,
    input  logic [RW-1:0] s1_rd,
    input  logic          s1_rd_en,
    input  logic          s1_cr_wr,
    input  logic          s1_xer_wr,
    input  logic          s1_cr_rd,
    input  logic [FW-1:0] s1_crf,
    input  logic          dc_miss,
    input  logic [RW-1:0] dc_miss_tag,
    input  logic          fill_done,
    output logic          s0_go,
    output logic [1:0]    s0_pipe,
    output logic          s1_go,
    output logic [1:0]    s1_pipe
);
    cls_info_t         inf0, inf1;
    logic [NREG-1:0]   gpr_busy;
    logic [NCRF-1:0]   cr_busy;
    logic              mb_en;
    logic [RW-1:0]     mb_tag;
    logic              haz0, haz1, dep1, conflict;
    logic              ld0_fire, ld1_fire, cr0_fire, cr1_fire;

    dp_classify u_cls0 (.cls(s0_cls), .cr_wr(s0_cr_wr), .xer_wr(s0_xer_wr), .info(inf0));
    dp_classify u_cls1 (.cls(s1_cls), .cr_wr(s1_cr_wr), .xer_wr(s1_xer_wr), .info(inf1));

    dp_countdown_sb #(.ENTRIES(NREG), .MAXV(LD_GAP - 1)) u_gpr_sb (
        .clk(clk), .rst_n(rst_n),
        .set_a_en(ld0_fire), .set_a_idx(s0_rd),
        .set_b_en(ld1_fire), .set_b_idx(s1_rd),
        .busy(gpr_busy)
    );

    dp_countdown_sb #(.ENTRIES(NCRF), .MAXV(CR_HOLD)) u_cr_sb (
        .clk(clk), .rst_n(rst_n),
        .set_a_en(cr0_fire), .set_a_idx(s0_crf),
        .set_b_en(cr1_fire), .set_b_idx(s1_crf),
        .busy(cr_busy)
    );

    dp_miss_fsm #(.IW(RW)) u_miss (
        .clk(clk), .rst_n(rst_n),
        .dc_miss(dc_miss), .dc_miss_tag(dc_miss_tag), .fill_done(fill_done),
        .blk_en(mb_en), .blk_tag(mb_tag)
    );

    always_comb begin
        haz0 = (s0_ra_en && (gpr_busy[s0_ra] || (mb_en && mb_tag == s0_ra))) ||
               (s0_rb_en && (gpr_busy[s0_rb] || (mb_en && mb_tag == s0_rb))) ||
               (s0_cr_rd && cr_busy[s0_crf]);
        haz1 = (s1_ra_en && (gpr_busy[s1_ra] || (mb_en && mb_tag == s1_ra))) ||
               (s1_rb_en && (gpr_busy[s1_rb] || (mb_en && mb_tag == s1_rb))) ||
               (s1_cr_rd && cr_busy[s1_crf]);
        dep1 = (s0_rd_en && ((s1_ra_en && s1_ra == s0_rd) || (s1_rb_en && s1_rb == s0_rd))) ||
               (s0_cr_wr && s1_cr_rd && s1_crf == s0_crf);
        conflict = (inf0.to_l && inf1.to_l) || (inf0.i_only && inf1.i_only);

        s0_go = s0_valid && !haz0;
        s1_go = s0_go && s1_valid && !haz1 && !dep1 && !conflict;

        if (!s0_go)            s0_pipe = PIPE_NONE;
        else if (inf0.to_l)    s0_pipe = PIPE_L;
        else if (inf0.i_only)  s0_pipe = PIPE_I;
        else if (s1_go && inf1.i_only) s0_pipe = PIPE_J;
        else                   s0_pipe = PIPE_I;

        if (!s1_go)            s1_pipe = PIPE_NONE;
        else if (inf1.to_l)    s1_pipe = PIPE_L;
        else if (inf1.i_only)  s1_pipe = PIPE_I;
        else                   s1_pipe = PIPE_J;

        ld0_fire = s0_go && inf0.is_load && s0_rd_en;
        ld1_fire = s1_go && inf1.is_load && s1_rd_en;
        cr0_fire = s0_go && inf0.long_cr;
        cr1_fire = s1_go && inf1.long_cr;
    end

    assert_in_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s1_go |-> s0_go);
    assert_distinct_pipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_go && s1_go) |-> (s0_pipe != s1_pipe));
    assert_lsu_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_go && (s0_cls == CL_LOAD || s0_cls == CL_STORE)) |-> (s0_pipe == PIPE_L));
    assert_pair_dep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_go && s0_rd_en) |-> !(s1_ra_en && s1_ra == s0_rd));
    assert_load_use_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld0_fire |=> !(s0_go && s0_ra_en && s0_ra == $past(s0_rd)));
    assert_long_cr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_fire |=> !(s0_go && s0_cr_rd && s0_crf == $past(s0_crf)));
endmodule

// File: tb/tb_dual_issue_pairer.sv
`timescale 1ns/1ps
module tb_dual_issue_pairer;

    typedef struct packed {
        logic       v;
        logic [2:0] cls;
        logic [4:0] ra;
        logic       ra_en;
        logic [4:0] rb;
        logic       rb_en;
        logic [4:0] rd;
        logic       rd_en;
        logic       crw;
        logic       xerw;
        logic       crr;
        logic [2:0] crf;
    } slot_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    slot_t sl0, sl1;
    logic dc_miss = 1'b0;
    logic [4:0] dc_miss_tag = '0;
    logic fill_done = 1'b0;
    logic s0_go, s1_go;
    logic [1:0] s0_pipe, s1_pipe;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_issue_pairer dut (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(sl0.v), .s0_cls(sl0.cls), .s0_ra(sl0.ra), .s0_ra_en(sl0.ra_en),
        .s0_rb(sl0.rb), .s0_rb_en(sl0.rb_en), .s0_rd(sl0.rd), .s0_rd_en(sl0.rd_en),
        .s0_cr_wr(sl0.crw), .s0_xer_wr(sl0.xerw), .s0_cr_rd(sl0.crr), .s0_crf(sl0.crf),
        .s1_valid(sl1.v), .s1_cls(sl1.cls), .s1_ra(sl1.ra), .s1_ra_en(sl1.ra_en),
        .s1_rb(sl1.rb), .s1_rb_en(sl1.rb_en), .s1_rd(sl1.rd), .s1_rd_en(sl1.rd_en),
        .s1_cr_wr(sl1.crw), .s1_xer_wr(sl1.xerw), .s1_cr_rd(sl1.crr), .s1_crf(sl1.crf),
        .dc_miss(dc_miss), .dc_miss_tag(dc_miss_tag), .fill_done(fill_done),
        .s0_go(s0_go), .s0_pipe(s0_pipe), .s1_go(s1_go), .s1_pipe(s1_pipe)
    );

    // class: 0 ALU,1 LOAD,2 STORE,3 BRANCH,4 MULDIV,5 SYS,6 SPR,7 MTCR
    function automatic slot_t mk(input logic [2:0] cls, input logic [4:0] ra, input logic ra_en,
                                 input logic [4:0] rd, input logic rd_en, input logic crw,
                                 input logic xerw, input logic crr, input logic [2:0] crf);
        slot_t s;
        s = '0;
        s.v = 1'b1; s.cls = cls; s.ra = ra; s.ra_en = ra_en; s.rd = rd; s.rd_en = rd_en;
        s.crw = crw; s.xerw = xerw; s.crr = crr; s.crf = crf;
        return s;
    endfunction

    task automatic chk(input string req, input string what, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic present(input slot_t a, input slot_t b);
        sl0 = a; sl1 = b;
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        sl0 = '0; sl1 = '0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset_state();
        present('0, '0);
        chk("R11", "go0 idle", {3'b0, s0_go}, 4'd0);
        chk("R11", "pipe0 idle", {2'b0, s0_pipe}, 4'd0);
        chk("R11", "go1 idle", {3'b0, s1_go}, 4'd0);
        present(mk(3'd0, 5'd5, 1, 5'd6, 1, 0, 0, 0, 3'd0), mk(3'd3, 5'd0, 0, 5'd0, 0, 0, 0, 1, 3'd2));
        chk("R11", "free gpr go0", {3'b0, s0_go}, 4'd1);
        chk("R11", "free crf go1", {3'b0, s1_go}, 4'd1);
        idle(3);
    endtask

    task automatic t_pipes();
        present(mk(3'd1, 5'd0, 0, 5'd10, 1, 0, 0, 0, 3'd0), '0);
        chk("R1", "load pipe", {2'b0, s0_pipe}, 4'd1);
        idle(3);
        present(mk(3'd2, 5'd1, 1, 5'd0, 0, 0, 0, 0, 3'd0), mk(3'd0, 5'd2, 1, 5'd3, 1, 0, 0, 0, 3'd0));
        chk("R1", "store pipe0", {2'b0, s0_pipe}, 4'd1);
        chk("R3", "flex beside store pipe1", {2'b0, s1_pipe}, 4'd3);
        idle(3);
        present(mk(3'd4, 5'd1, 1, 5'd4, 1, 0, 0, 0, 3'd0), '0);
        chk("R2", "muldiv pipe", {2'b0, s0_pipe}, 4'd2);
        idle(3);
        present(mk(3'd0, 5'd1, 1, 5'd4, 1, 0, 1, 0, 3'd0), mk(3'd1, 5'd2, 1, 5'd11, 1, 0, 0, 0, 3'd0));
        chk("R2", "xer alu pipe0", {2'b0, s0_pipe}, 4'd2);
        chk("R1", "load slot1 pipe", {2'b0, s1_pipe}, 4'd1);
        idle(3);
        present(mk(3'd6, 5'd0, 0, 5'd4, 1, 0, 0, 0, 3'd0), mk(3'd0, 5'd2, 1, 5'd12, 1, 0, 0, 0, 3'd0));
        chk("R2", "spr pipe0", {2'b0, s0_pipe}, 4'd2);
        chk("R3", "flex beside spr", {2'b0, s1_pipe}, 4'd3);
        idle(3);
        present(mk(3'd0, 5'd1, 1, 5'd4, 1, 0, 0, 0, 3'd0), mk(3'd0, 5'd2, 1, 5'd12, 1, 0, 0, 0, 3'd0));
        chk("R3", "flex pair pipe0", {2'b0, s0_pipe}, 4'd2);
        chk("R3", "flex pair pipe1", {2'b0, s1_pipe}, 4'd3);
        idle(3);
        present(mk(3'd0, 5'd1, 1, 5'd4, 1, 0, 0, 0, 3'd0), mk(3'd3, 5'd0, 0, 5'd0, 0, 0, 0, 0, 3'd0));
        chk("R3", "flex before branch pipe0", {2'b0, s0_pipe}, 4'd3);
        chk("R2", "branch pipe1", {2'b0, s1_pipe}, 4'd2);
        idle(3);
        present(mk(3'd0, 5'd1, 1, 5'd4, 1, 0, 0, 0, 3'd0), '0);
        chk("R3", "flex alone pipe0", {2'b0, s0_pipe}, 4'd2);
        idle(3);
    endtask

    task automatic t_conflict();
        present(mk(3'd1, 5'd1, 1, 5'd13, 1, 0, 0, 0, 3'd0), mk(3'd2, 5'd2, 1, 5'd0, 0, 0, 0, 0, 3'd0));
        chk("R4", "two L go0", {3'b0, s0_go}, 4'd1);
        chk("R4", "two L go1", {3'b0, s1_go}, 4'd0);
        chk("R5", "two L pipe1 none", {2'b0, s1_pipe}, 4'd0);
        idle(3);
        present(mk(3'd3, 5'd0, 0, 5'd0, 0, 0, 0, 0, 3'd0), mk(3'd5, 5'd0, 0, 5'd0, 0, 0, 0, 0, 3'd0));
        chk("R4", "two I-only go1", {3'b0, s1_go}, 4'd0);
        idle(3);
    endtask

    task automatic t_order();
        slot_t a;
        a = mk(3'd0, 5'd1, 1, 5'd4, 1, 0, 0, 0, 3'd0);
        a.v = 1'b0;
        present(a, mk(3'd0, 5'd2, 1, 5'd3, 1, 0, 0, 0, 3'd0));
        chk("R5", "invalid slot0 go1", {3'b0, s1_go}, 4'd0);
        chk("R5", "invalid slot0 pipe0", {2'b0, s0_pipe}, 4'd0);
        idle(3);
    endtask

    task automatic t_pair_dep();
        slot_t b;
        b = mk(3'd0, 5'd1, 1, 5'd3, 1, 0, 0, 0, 3'd0);
        b.rb = 5'd9; b.rb_en = 1'b1;
        present(mk(3'd0, 5'd1, 1, 5'd9, 1, 0, 0, 0, 3'd0), b);
        chk("R6", "rb reads slot0 rd go1", {3'b0, s1_go}, 4'd0);
        idle(3);
        b.rb = 5'd8;
        present(mk(3'd0, 5'd1, 1, 5'd9, 1, 0, 0, 0, 3'd0), b);
        chk("R6", "independent go1", {3'b0, s1_go}, 4'd1);
        idle(3);
        present(mk(3'd2, 5'd1, 1, 5'd0, 0, 1, 0, 0, 3'd4), mk(3'd3, 5'd0, 0, 5'd0, 0, 0, 0, 1, 3'd4));
        chk("R6", "crf dep go1", {3'b0, s1_go}, 4'd0);
        idle(3);
    endtask

    task automatic t_load_use();
        present(mk(3'd1, 5'd1, 1, 5'd5, 1, 0, 0, 0, 3'd0), '0);
        chk("R7", "load go t", {3'b0, s0_go}, 4'd1);
        step();
        present(mk(3'd0, 5'd5, 1, 5'd6, 1, 0, 0, 0, 3'd0), mk(3'd0, 5'd1, 1, 5'd2, 1, 0, 0, 0, 3'd0));
        chk("R7", "consumer t+1", {3'b0, s0_go}, 4'd0);
        chk("R5", "stalled slot0 blocks go1", {3'b0, s1_go}, 4'd0);
        step();
        present(mk(3'd0, 5'd5, 1, 5'd6, 1, 0, 0, 0, 3'd0), '0);
        chk("R7", "consumer t+2", {3'b0, s0_go}, 4'd0);
        step();
        present(mk(3'd0, 5'd5, 1, 5'd6, 1, 0, 0, 0, 3'd0), '0);
        chk("R7", "consumer t+3", {3'b0, s0_go}, 4'd1);
        idle(3);
    endtask

    task automatic t_cr_plain();
        present(mk(3'd0, 5'd1, 1, 5'd0, 0, 1, 0, 0, 3'd3), mk(3'd3, 5'd0, 0, 5'd0, 0, 0, 0, 1, 3'd3));
        chk("R8", "cr alu + branch same cycle go1", {3'b0, s1_go}, 4'd0);
        step();
        present(mk(3'd3, 5'd0, 0, 5'd0, 0, 0, 0, 1, 3'd3), '0);
        chk("R8", "branch t+1", {3'b0, s0_go}, 4'd1);
        idle(3);
    endtask

    task automatic t_cr_long();
        present(mk(3'd4, 5'd1, 1, 5'd0, 0, 1, 0, 0, 3'd2), '0);
        step();
        present(mk(3'd3, 5'd0, 0, 5'd0, 0, 0, 0, 1, 3'd2), '0);
        chk("R9", "muldiv branch t+1", {3'b0, s0_go}, 4'd0);
        step();
        present(mk(3'd3, 5'd0, 0, 5'd0, 0, 0, 0, 1, 3'd2), '0);
        chk("R9", "muldiv branch t+2", {3'b0, s0_go}, 4'd1);
        idle(3);
        present(mk(3'd7, 5'd1, 1, 5'd0, 0, 1, 0, 0, 3'd6), '0);
        step();
        present(mk(3'd3, 5'd0, 0, 5'd0, 0, 0, 0, 1, 3'd6), '0);
        chk("R9", "mtcr branch t+1", {3'b0, s0_go}, 4'd0);
        idle(3);
    endtask

    task automatic t_miss();
        present(mk(3'd1, 5'd1, 1, 5'd7, 1, 0, 0, 0, 3'd0), '0);
        step();
        dc_miss = 1'b1; dc_miss_tag = 5'd7;
        present(mk(3'd0, 5'd7, 1, 5'd6, 1, 0, 0, 0, 3'd0), '0);
        step();
        dc_miss = 1'b0;
        present(mk(3'd0, 5'd7, 1, 5'd6, 1, 0, 0, 0, 3'd0), '0);
        chk("R10", "miss t+2", {3'b0, s0_go}, 4'd0);
        step();
        present(mk(3'd0, 5'd7, 1, 5'd6, 1, 0, 0, 0, 3'd0), '0);
        chk("R10", "miss held t+3", {3'b0, s0_go}, 4'd0);
        present(mk(3'd0, 5'd8, 1, 5'd6, 1, 0, 0, 0, 3'd0), '0);
        chk("R10", "other reg during miss", {3'b0, s0_go}, 4'd1);
        step();
        fill_done = 1'b1;
        present(mk(3'd0, 5'd7, 1, 5'd6, 1, 0, 0, 0, 3'd0), '0);
        chk("R10", "fill cycle", {3'b0, s0_go}, 4'd0);
        step();
        fill_done = 1'b0;
        present(mk(3'd0, 5'd7, 1, 5'd6, 1, 0, 0, 0, 3'd0), '0);
        chk("R10", "after fill", {3'b0, s0_go}, 4'd1);
        idle(3);
    endtask

    initial begin
        sl0 = '0; sl1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_pipes();
        t_conflict();
        t_order();
        t_pair_dep();
        t_load_use();
        t_cr_plain();
        t_cr_long();
        t_miss();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule